// File: doc/BRIEF.md
# Multi-mode PWM Timer/Counter

An 8-bit timer/counter with one compare channel and a waveform generator. The counter advances on every clock in which a prescaled enable (`tick`) is high. A 2-bit mode field selects one of four counting schemes:

- free-running count with wrap-around;
- clear-on-compare;
- single-slope fast PWM;
- dual-slope phase-correct PWM.

A 2-bit output-action field decides what a compare match does to the waveform output.

Software reaches the block through simple write strobes. These strobes load the count, load the compare value, and load the mode and action fields. They also give a forced-compare pulse and clear the two sticky flags. The compare value is staged in a buffer and reaches the comparator at the turn of the period, but only in the two PWM modes. In the other modes a write takes effect at once.

A write to the counter blocks the compare in that cycle and on the next timer tick. This lets software reload the count without producing a spurious edge.

Top module: `wavetimer8`

## Requirements
- R1: After reset the count, both compare registers, mode (00), action field (00), waveform output, output enable and both flags are all zero.
- R2: The count changes only in a cycle where `tick` is high or `cnt_wr` is high. `cnt_wr` loads `cnt_wdata` and takes priority over counting.
- R3: In modes 00 (normal), 10 (CTC) and 11 (fast PWM), a tick while the count is 0xFF sets `ovf_flag` on the next clock. `ovf_clr` clears the flag, but a set in the same cycle wins.
- R4: A tick while the count equals the active compare value is a match. A match sets `cmp_flag` on the next clock, and a set beats `cmp_clr`. In mode 10 a match loads the count with 0 instead of incrementing it.
- R5: In modes 00 and 10 a match drives the output from the action field: 00 no action (output enable low), 01 toggle, 10 drive 0, 11 drive 1. The output enable is high for any non-zero action.
- R6: In modes 00 and 10, `force_cmp` applies the action-field operation without setting `cmp_flag`. A force and a match in the same cycle apply the operation once. In PWM modes, `force_cmp` has no effect.
- R7: A counter write suppresses matches in its own cycle and on the next tick. A suppressed match sets no flag, takes no output action and does not clear the count in mode 10.
- R8: In modes 00 and 10 a compare write is used by the comparator from the next cycle. In modes 01 and 11 it only fills a buffer (read back on `cmp_q`). The buffer is copied to the comparator on the tick taken while the count is 0xFF.
- R9: In mode 11 with action 10, a match drives 0 and the tick at 0xFF drives 1. Action 11 gives the inverse. When both fall on the same tick, the 0xFF action wins. The output enable follows action bit 1.
- R10: In mode 01 the count climbs from 0 to 0xFF and descends back to 0, repeating. A tick while the count is 0 sets `ovf_flag`.
- R11: In mode 01 with action 10, a match on the rising slope drives 0 and a match on the falling slope drives 1. Action 11 gives the inverse. A match at count 0 counts as rising and a match at 0xFF counts as falling.
- R12: A mode/action write uses the old action for a match in the same cycle. The new action applies from the following match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled count enable |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write data |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | 8 | Compare value write data |
| ctl_wr | input | 1 | Mode/action write strobe |
| ctl_mode | input | 2 | Mode: 00 normal, 01 dual-slope, 10 CTC, 11 fast |
| ctl_com | input | 2 | Output action field |
| force_cmp | input | 1 | Forced-compare strobe |
| ovf_clr | input | 1 | Overflow flag clear |
| cmp_clr | input | 1 | Match flag clear |
| cnt_q | output | 8 | Current count |
| cmp_q | output | 8 | Compare value as written (buffer) |
| mode_q | output | 2 | Current mode |
| com_q | output | 2 | Current action field |
| wave_out | output | 1 | Waveform output |
| wave_oe | output | 1 | Waveform output enable |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky match flag |

## Verification
Several pairs of events can fall in the same cycle:

- a counter write and a timer tick whose compare would have matched;
- a forced compare and a real match;
- a flag clear and a flag set;
- a mode/action write and a match.

Directed sequences place each pair on the same clock edge. Long runs with random ticks and strobes then repeat these collisions in every mode. On every clock a behavioural reference model in the bench decides which side wins, and the bench compares all outputs against it.

// File: rtl/wavetimer8.sv
module wavetimer8 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic         ctl_wr,
  input  logic [1:0]   ctl_mode,
  input  logic [1:0]   ctl_com,
  input  logic         force_cmp,
  input  logic         ovf_clr,
  input  logic         cmp_clr,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cmp_q,
  output logic [1:0]   mode_q,
  output logic [1:0]   com_q,
  output logic         wave_out,
  output logic         wave_oe,
  output logic         ovf_flag,
  output logic         cmp_flag
);
  localparam logic [W-1:0] TOPV = '1;
  localparam logic [W-1:0] BOTV = '0;
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [1:0] M_NORM = 2'b00;
  localparam logic [1:0] M_DUAL = 2'b01;
  localparam logic [1:0] M_CTC  = 2'b10;
  localparam logic [1:0] M_FAST = 2'b11;

  logic [W-1:0] cnt, ocr_buf, ocr_act, cnt_nx;
  logic [1:0]   mode, com;
  logic         oc, oc_nx, ovf, cf, dir, blk;

  wire          pwm      = mode[0];
  wire [W-1:0]  cmp_eff  = pwm ? ocr_act : ocr_buf;
  wire          at_top   = (cnt == TOPV);
  wire          at_bot   = (cnt == BOTV);
  wire          adv      = tick & ~cnt_wr;
  wire          hit      = adv & ~blk & (cnt == cmp_eff);
  wire          slope_up = at_bot | (~at_top & dir);
  wire          ovf_set  = adv & ((mode == M_DUAL) ? at_bot : at_top);

  always_comb begin
    unique case (mode)
      M_CTC:   cnt_nx = hit ? BOTV : cnt + ONE;
      M_DUAL:  cnt_nx = slope_up ? cnt + ONE : cnt - ONE;
      default: cnt_nx = cnt + ONE;
    endcase
  end

  always_comb begin
    oc_nx = oc;
    if (!pwm) begin
      if (hit || force_cmp) begin
        unique case (com)
          2'b01:   oc_nx = ~oc;
          2'b10:   oc_nx = 1'b0;
          2'b11:   oc_nx = 1'b1;
          default: oc_nx = oc;
        endcase
      end
    end else if (com[1]) begin
      if (mode == M_FAST) begin
        if (adv && at_top) oc_nx = ~com[0];
        else if (hit)      oc_nx = com[0];
      end else if (hit) begin
        oc_nx = slope_up ? com[0] : ~com[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= BOTV;
      ocr_buf <= BOTV;
      ocr_act <= BOTV;
      mode    <= M_NORM;
      com     <= 2'b00;
      oc      <= 1'b0;
      ovf     <= 1'b0;
      cf      <= 1'b0;
      dir     <= 1'b1;
      blk     <= 1'b0;
    end else begin
      if (cnt_wr)   cnt <= cnt_wdata;
      else if (adv) cnt <= cnt_nx;

      if (cnt_wr)    blk <= 1'b1;
      else if (tick) blk <= 1'b0;

      if (!pwm)                ocr_act <= ocr_buf;
      else if (adv && at_top)  ocr_act <= ocr_buf;
      if (cmp_wr) ocr_buf <= cmp_wdata;

      if (ctl_wr) begin
        mode <= ctl_mode;
        com  <= ctl_com;
        dir  <= 1'b1;
      end else if (adv && mode == M_DUAL) begin
        dir  <= slope_up;
      end

      oc  <= oc_nx;
      ovf <= ovf_set | (ovf & ~ovf_clr);
      cf  <= hit | (cf & ~cmp_clr);
    end
  end

  assign cnt_q    = cnt;
  assign cmp_q    = ocr_buf;
  assign mode_q   = mode;
  assign com_q    = com;
  assign wave_out = oc;
  assign wave_oe  = pwm ? com[1] : (com != 2'b00);
  assign ovf_flag = ovf;
  assign cmp_flag = cf;
endmodule

// File: rtl/wavetimer8_chk.sv
module wavetimer8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         cnt_wr,
  input logic [W-1:0] cnt_q,
  input logic [1:0]   mode_q,
  input logic [1:0]   com_q,
  input logic         wave_out,
  input logic         ovf_flag,
  input logic         cmp_flag
);
  localparam logic [W-1:0] TOPV = '1;

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt_q));

  // R3
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(tick));

  // R4
  match_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_flag) |-> $past(tick));

  // R7
  wr_block_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> !$rose(cmp_flag));

  // R7
  wr_block_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr ##1 (tick && !cnt_wr) |=> !$rose(cmp_flag));

  // R5
  disc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[0] && com_q == 2'b00) |=> $stable(wave_out));

  // R6
  pwm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[0] && !tick) |=> $stable(wave_out));

  // R10
  dual_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01 && tick && !cnt_wr && cnt_q == TOPV) |=> (cnt_q == TOPV - 1'b1));
endmodule

bind wavetimer8 wavetimer8_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr), .cnt_q(cnt_q),
  .mode_q(mode_q), .com_q(com_q), .wave_out(wave_out),
  .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
);

// File: tb/wavetimer8_tb.sv
`timescale 1ns/1ps
module wavetimer8_tb;
  logic clk = 0, rst_n = 0;
  logic tick, cnt_wr, cmp_wr, ctl_wr, force_cmp, ovf_clr, cmp_clr;
  logic [7:0] cnt_wdata, cmp_wdata;
  logic [1:0] ctl_mode, ctl_com;
  logic [7:0] cnt_q, cmp_q;
  logic [1:0] mode_q, com_q;
  logic wave_out, wave_oe, ovf_flag, cmp_flag;

  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  wavetimer8 #(.W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .ctl_wr(ctl_wr), .ctl_mode(ctl_mode),
    .ctl_com(ctl_com), .force_cmp(force_cmp), .ovf_clr(ovf_clr), .cmp_clr(cmp_clr),
    .cnt_q(cnt_q), .cmp_q(cmp_q), .mode_q(mode_q), .com_q(com_q),
    .wave_out(wave_out), .wave_oe(wave_oe), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  logic [7:0] m_cnt, m_buf, m_act, eff;
  logic [1:0] m_mode, m_com;
  bit m_oc, m_ovf, m_cf, m_dir, m_blk, m_ok;
  bit pwm, adv, hit, top, bot, up, noc;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_buf = 0; m_act = 0; m_mode = 0; m_com = 0;
      m_oc = 0; m_ovf = 0; m_cf = 0; m_dir = 1; m_blk = 0; m_ok = 0;
    end else begin
      pwm = m_mode[0];
      eff = pwm ? m_act : m_buf;
      adv = tick && !cnt_wr;
      hit = adv && !m_blk && (m_cnt == eff);
      top = (m_cnt == 8'hFF);
      bot = (m_cnt == 8'h00);
      up  = bot ? 1'b1 : (top ? 1'b0 : m_dir);
      noc = m_oc;
      if (!pwm) begin
        if (hit || force_cmp)
          case (m_com)
            2'd1: noc = !m_oc;
            2'd2: noc = 0;
            2'd3: noc = 1;
            default: ;
          endcase
      end else if (m_com[1]) begin
        if (m_mode == 2'd3) begin
          if (adv && top) noc = !m_com[0];
          else if (hit)   noc = m_com[0];
        end else if (hit) noc = up ? m_com[0] : !m_com[0];
      end
      if (adv && ((m_mode == 2'd1) ? bot : top)) m_ovf = 1;
      else if (ovf_clr) m_ovf = 0;
      if (hit) m_cf = 1;
      else if (cmp_clr) m_cf = 0;
      if (!pwm) m_act = m_buf;
      else if (adv && top) m_act = m_buf;
      if (cmp_wr) m_buf = cmp_wdata;
      if (cnt_wr) m_cnt = cnt_wdata;
      else if (adv)
        case (m_mode)
          2'd2: m_cnt = hit ? 8'd0 : m_cnt + 8'd1;
          2'd1: m_cnt = up ? m_cnt + 8'd1 : m_cnt - 8'd1;
          default: m_cnt = m_cnt + 8'd1;
        endcase
      if (ctl_wr) m_dir = 1;
      else if (adv && m_mode == 2'd1) m_dir = up;
      if (cnt_wr) m_blk = 1;
      else if (tick) m_blk = 0;
      if (ctl_wr) begin m_mode = ctl_mode; m_com = ctl_com; end
      m_oc = noc;
      m_ok = 1;
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(negedge clk) begin
    if (rst_n && m_ok) begin
      logic [25:0] a, e;
      a = {cnt_q, cmp_q, mode_q, com_q, wave_out, wave_oe, ovf_flag, cmp_flag};
      e = {m_cnt, m_buf, m_mode, m_com, m_oc,
           (m_mode[0] ? m_com[1] : (m_com != 0)), m_ovf, m_cf};
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s model mismatch: actual=%h expected=%h", cur_req, a, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL R2 watchdog: actual=%0d cycles expected<%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_in();
    tick = 0; cnt_wr = 0; cmp_wr = 0; ctl_wr = 0; force_cmp = 0;
    ovf_clr = 0; cmp_clr = 0;
  endtask

  task automatic run(int n, bit tk = 1);
    for (int i = 0; i < n; i++) begin
      clr_in(); tick = tk; @(negedge clk);
    end
    clr_in();
  endtask

  task automatic wr_cnt(logic [7:0] v, bit tk = 0);
    clr_in(); tick = tk; cnt_wr = 1; cnt_wdata = v; @(negedge clk); clr_in();
  endtask

  task automatic wr_cmp(logic [7:0] v);
    clr_in(); cmp_wr = 1; cmp_wdata = v; @(negedge clk); clr_in();
  endtask

  task automatic wr_ctl(logic [1:0] m, logic [1:0] c, bit tk = 0);
    clr_in(); tick = tk; ctl_wr = 1; ctl_mode = m; ctl_com = c; @(negedge clk); clr_in();
  endtask

  task automatic pulse(bit f, bit oclr, bit cclr, bit tk = 0);
    clr_in(); tick = tk; force_cmp = f; ovf_clr = oclr; cmp_clr = cclr;
    @(negedge clk); clr_in();
  endtask

  task automatic rnd_phase(logic [1:0] m, logic [1:0] c, int n);
    wr_ctl(m, c);
    for (int i = 0; i < n; i++) begin
      int r;
      clr_in();
      r = $urandom % 100;
      tick = ($urandom % 4) != 0;
      if (r < 2) begin cnt_wr = 1; cnt_wdata = 8'($urandom); end
      if (r >= 2 && r < 5) begin cmp_wr = 1; cmp_wdata = 8'($urandom); end
      if (r >= 94) force_cmp = 1;
      if (r % 9 == 0) ovf_clr = 1;
      if (r % 7 == 0) cmp_clr = 1;
      @(negedge clk);
    end
    clr_in();
  endtask

  initial begin
    clr_in(); cnt_wdata = 0; cmp_wdata = 0; ctl_mode = 0; ctl_com = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 cnt", cnt_q, 0);
    chk("R1 wave", wave_out, 0);
    chk("R1 oe", wave_oe, 0);
    chk("R1 flags", {ovf_flag, cmp_flag}, 0);
    chk("R1 mode", mode_q, 0);

    // R2 counting only on tick
    cur_req = "R2";
    run(5, 0);
    chk("R2 idle", cnt_q, 0);
    run(3);
    chk("R2 count", cnt_q, 3);
    wr_cnt(8'hF0, 1);
    chk("R2 write wins", cnt_q, 8'hF0);

    // R3 overflow
    cur_req = "R3";
    run(15);
    chk("R3 at max", {cnt_q, 7'd0, ovf_flag}, 16'hFF00);
    run(1);
    chk("R3 wrap", {cnt_q, 7'd0, ovf_flag}, 16'h0001);
    pulse(0, 1, 0);
    chk("R3 clear", ovf_flag, 0);
    wr_cnt(8'hFF);
    pulse(0, 1, 0, 1);
    chk("R3 set wins", ovf_flag, 1);

    // R4/R5 CTC with toggle
    cur_req = "R4";
    wr_ctl(2'b10, 2'b01);
    wr_cmp(8'd5);
    wr_cnt(8'd0);
    pulse(0, 1, 1);
    run(5);
    chk("R4 before match", {cnt_q, 7'd0, cmp_flag}, 16'h0500);
    run(1);
    chk("R4 ctc clear", cnt_q, 0);
    chk("R4 flag", cmp_flag, 1);
    chk("R5 toggle", {wave_out, wave_oe}, 2'b11);

    // R7 write blocks next match
    cur_req = "R7";
    pulse(0, 0, 1);
    wr_cnt(8'd5);
    run(1);
    chk("R7 blocked cnt", cnt_q, 6);
    chk("R7 blocked flag", cmp_flag, 0);
    chk("R7 blocked wave", wave_out, 1);

    // R6 force
    cur_req = "R6";
    pulse(1, 0, 0);
    chk("R6 force wave", wave_out, 0);
    chk("R6 force noflag", cmp_flag, 0);
    wr_cnt(8'd4);
    run(1);
    pulse(1, 0, 0, 1);
    chk("R6 force+match single", {wave_out, cmp_flag}, 2'b11);
    chk("R6 force+match cnt", cnt_q, 0);

    // R8/R9 fast PWM with buffered compare
    cur_req = "R9";
    wr_cmp(8'h80);
    wr_ctl(2'b11, 2'b10);
    wr_cnt(8'hFE);
    run(2);
    chk("R9 set at wrap", {cnt_q, 7'd0, wave_out}, 16'h0001);
    wr_cmp(8'h20);
    run(8'h30);
    chk("R8 buffered", {cmp_q, 7'd0, wave_out}, 16'h2001);
    run(8'h51);
    chk("R9 clear on match", {cnt_q, 7'd0, wave_out}, 16'h8100);
    run(8'h7F);
    chk("R9 wrap again", {cnt_q, 7'd0, wave_out}, 16'h0001);
    run(8'h21);
    chk("R8 new compare live", {cnt_q, 7'd0, wave_out}, 16'h2100);

    // R10/R11 dual slope
    cur_req = "R11";
    pulse(0, 1, 1);
    wr_ctl(2'b01, 2'b10);
    wr_cmp(8'h10);
    wr_cnt(8'hFD);
    run(3);
    chk("R10 turn at top", cnt_q, 8'hFE);
    run(8'hEF);
    chk("R11 set on falling", {cnt_q, 7'd0, wave_out}, 16'h0F01);
    chk("R10 no ovf on descent", ovf_flag, 0);
    run(8'h10);
    chk("R10 bottom", {cnt_q, 7'd0, ovf_flag}, 16'h0101);
    run(8'h10);
    chk("R11 clear on rising", {cnt_q, 7'd0, wave_out}, 16'h1100);

    // R12 action change timing
    cur_req = "R12";
    wr_ctl(2'b00, 2'b01);
    wr_cmp(8'd3);
    wr_cnt(8'd2);
    run(1);
    wr_ctl(2'b00, 2'b10, 1);
    chk("R12 old action", wave_out, 1);
    chk("R12 field", com_q, 2'b10);
    wr_cnt(8'd2);
    run(2);
    chk("R12 new action", wave_out, 0);

    // R6 force ignored in PWM
    cur_req = "R6";
    wr_ctl(2'b11, 2'b11);
    pulse(1, 0, 0);
    chk("R6 pwm force ignored", wave_out, 0);

    // random collisions in every mode
    cur_req = "R3";  rnd_phase(2'b00, 2'b01, 1500);
    cur_req = "R5";  rnd_phase(2'b00, 2'b11, 1500);
    cur_req = "R4";  rnd_phase(2'b10, 2'b01, 1500);
    cur_req = "R9";  rnd_phase(2'b11, 2'b10, 3000);
    cur_req = "R9";  rnd_phase(2'b11, 2'b11, 3000);
    cur_req = "R11"; rnd_phase(2'b01, 2'b10, 4000);
    cur_req = "R11"; rnd_phase(2'b01, 2'b11, 4000);

    run(2, 0);
    summary();
    $finish;
  end
endmodule